// File: doc/BRIEF.md
# Demand-Responsive Two-Road Signal Controller

This block drives the lamps at a crossing of a busy main road and a lightly used side road. A four-phase Moore machine cycles through main green, main amber, side green and side amber. The main road keeps its green until a vehicle has been seen on the side road. The lamp outputs depend on the current phase alone.

Two down-counting timers set the phase lengths. The amber timer serves both amber phases. The green timer serves both green phases. Every length comes from an input bus and is captured when its phase begins. The side road has two green lengths, a short one and a long one. The long one is chosen when further traffic arrived during the previous side green. A raw presence sensor passes through a two-flop synchronizer and an edge detector. Each rising edge becomes a single-cycle pulse, and that pulse sets a sticky service request. A shared prescale parameter sets how many clock cycles make one timer unit.

Top module: `junction_signal_ctrl`

## Requirements
- R1: While reset is held, and in the phase entered when reset ends, the main green and side red lamps are lit (phase S0). No service request is pending after reset.
- R2: On each road exactly one lamp is lit in every cycle. The lamp patterns {main grn, amb, red, side grn, amb, red} are S0=100001, S1=010001, S2=001100 and S3=001010.
- R3: Without a pending request, the controller stays in S0 indefinitely, even after the green timer has run out.
- R4: Suppose a rising sensor edge is sampled at clock edge k while the main green timer has already run out. Then the main amber lamp is lit from edge k+3 onward.
- R5: A sensor held high produces only one request. Only a new low-to-high transition requests service again.
- R6: Each amber phase lasts `amber_len_i`*PRESCALE+1 cycles. A length of 0 gives one cycle.
- R7: With a request already pending, main green lasts `green_main_len_i`*PRESCALE+1 cycles from its start.
- R8: Side green normally lasts `green_side_short_i`*PRESCALE+1 cycles. It lasts `green_side_long_i`*PRESCALE+1 cycles when a sensor pulse reached the controller during the preceding side green.
- R9: The request is cleared when side green begins. After one full cycle with no new sensor edge, the controller rests in S0.
- R10: A length input is captured only at the start of its phase. Changing it during that phase does not change that phase's length.
- R11: Phases always advance in the fixed order S0, S1, S2, S3, S0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| car_raw_i | input | 1 | Unsynchronized side-road presence sensor |
| amber_len_i | input | LEN_W | Amber length in timer units |
| green_main_len_i | input | LEN_W | Main green length in timer units |
| green_side_short_i | input | LEN_W | Side green length at normal demand |
| green_side_long_i | input | LEN_W | Side green length at raised demand |
| main_grn_o | output | 1 | Main road green lamp |
| main_amb_o | output | 1 | Main road amber lamp |
| main_red_o | output | 1 | Main road red lamp |
| side_grn_o | output | 1 | Side road green lamp |
| side_amb_o | output | 1 | Side road amber lamp |
| side_red_o | output | 1 | Side road red lamp |

## Verification
A sensor edge takes three clock edges to reach the lamps: two synchronizer flops, then the request register, then the phase register. The bench therefore expects main amber exactly on the fourth falling edge after it raises the sensor. Phase lengths are counted at falling edges, from the first falling edge that shows a lamp pattern to the first that shows a different one. That count must equal length*PRESCALE+1, because the timer is loaded on the same edge that changes the phase, and the phase changes on the edge after the count reaches zero. Resting in S0 is checked over a window longer than the green timer, so that a request leaking through would have had time to show.

// File: rtl/junction_pkg.sv
package junction_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO    = 2'd0,
    PH_MAIN_AMBER = 2'd1,
    PH_SIDE_GO    = 2'd2,
    PH_SIDE_AMBER = 2'd3
  } phase_e;

  function automatic phase_e phase_succ(input phase_e p);
    case (p)
      PH_MAIN_GO:    return PH_MAIN_AMBER;
      PH_MAIN_AMBER: return PH_SIDE_GO;
      PH_SIDE_GO:    return PH_SIDE_AMBER;
      default:       return PH_MAIN_GO;
    endcase
  endfunction

endpackage

// File: rtl/presence_detect.sv
module presence_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic pulse_o
);
  logic [1:0] sync_q;
  logic       last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      last_q <= sync_q[1];
    end
  end

  assign pulse_o = sync_q[1] & ~last_q;

  // R5: a level held high yields one pulse only
  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int LEN_W    = 8,
  parameter int PRESCALE = 50_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             expired_o
);
  logic [LEN_W-1:0] count_q, count_d;
  logic             step;
  logic             running;
  logic             cnt_en;

  assign running = (count_q != '0);

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PRE_W = $clog2(PRESCALE);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;

      assign step   = (pre_q == PRE_W'(PRESCALE - 1));
      assign pre_en = load_i | running;

      always_comb begin
        if (load_i)    pre_d = '0;
        else if (step) pre_d = '0;
        else           pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end
    end else begin : g_nodiv
      assign step = 1'b1;
    end
  endgenerate

  assign cnt_en = load_i | (running & step);

  always_comb begin
    if (load_i) count_d = len_i;
    else        count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign expired_o = ~running;

  // R6: expiry holds until the next load
  assert_expired_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);

  // R10: between loads the count only moves downward
  assert_no_count_up_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (count_q <= $past(count_q)));

endmodule

// File: rtl/light_fsm.sv
module light_fsm
  import junction_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pulse_i,
  input  logic   amber_exp_i,
  input  logic   green_exp_i,
  output phase_e phase_o,
  output logic   amber_load_o,
  output logic   green_load_o,
  output logic   green_side_o,
  output logic   green_long_o
);
  phase_e state_q, state_d;
  logic   boot_q;
  logic   req_q, req_d;
  logic   ext_q, ext_d;
  logic   adv;
  logic   enter_side, enter_main;

  always_comb begin
    case (state_q)
      PH_MAIN_GO:    adv = green_exp_i & req_q & ~boot_q;
      PH_MAIN_AMBER: adv = amber_exp_i;
      PH_SIDE_GO:    adv = green_exp_i;
      default:       adv = amber_exp_i;
    endcase
    state_d    = phase_succ(state_q);
    enter_side = adv & (state_q == PH_MAIN_AMBER);
    enter_main = adv & (state_q == PH_SIDE_AMBER);
    req_d      = enter_side ? 1'b0 : (req_q | pulse_i);
    ext_d      = enter_side ? 1'b0 : (ext_q | (pulse_i & (state_q == PH_SIDE_GO)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_MAIN_GO;
      boot_q  <= 1'b1;
      req_q   <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      if (adv)    state_q <= state_d;
      if (boot_q) boot_q  <= 1'b0;
      req_q <= req_d;
      ext_q <= ext_d;
    end
  end

  assign phase_o      = state_q;
  assign amber_load_o = adv & ((state_q == PH_MAIN_GO) | (state_q == PH_SIDE_GO));
  assign green_load_o = boot_q | enter_side | enter_main;
  assign green_side_o = enter_side;
  assign green_long_o = ext_q;

  // R11: phases advance only to their successor
  assert_phase_order_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> (state_q == phase_succ($past(state_q))));

  // R3: no request keeps main green
  assert_main_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_MAIN_GO && !req_q) |=> (state_q == PH_MAIN_GO));

  // R9: request is gone once side green has begun
  assert_req_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SIDE_GO && $past(state_q) == PH_MAIN_AMBER) |-> !req_q);

  // R6: amber stays until its timer has run out
  assert_amber_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_MAIN_AMBER && !amber_exp_i) |=> (state_q == PH_MAIN_AMBER));

endmodule

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl
  import junction_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int PRESCALE = 50_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             car_raw_i,
  input  logic [LEN_W-1:0] amber_len_i,
  input  logic [LEN_W-1:0] green_main_len_i,
  input  logic [LEN_W-1:0] green_side_short_i,
  input  logic [LEN_W-1:0] green_side_long_i,
  output logic             main_grn_o,
  output logic             main_amb_o,
  output logic             main_red_o,
  output logic             side_grn_o,
  output logic             side_amb_o,
  output logic             side_red_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             pulse;
  logic             amber_exp, green_exp;
  logic             amber_load, green_load;
  logic             green_side, green_long;
  logic [LEN_W-1:0] green_len;
  phase_e           phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  presence_detect u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .raw_i  (car_raw_i),
    .pulse_o(pulse)
  );

  light_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .pulse_i     (pulse),
    .amber_exp_i (amber_exp),
    .green_exp_i (green_exp),
    .phase_o     (phase),
    .amber_load_o(amber_load),
    .green_load_o(green_load),
    .green_side_o(green_side),
    .green_long_o(green_long)
  );

  always_comb begin
    if (!green_side)     green_len = green_main_len_i;
    else if (green_long) green_len = green_side_long_i;
    else                 green_len = green_side_short_i;
  end

  phase_timer #(.LEN_W(LEN_W), .PRESCALE(PRESCALE)) u_amber_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (amber_load),
    .len_i    (amber_len_i),
    .expired_o(amber_exp)
  );

  phase_timer #(.LEN_W(LEN_W), .PRESCALE(PRESCALE)) u_green_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (green_load),
    .len_i    (green_len),
    .expired_o(green_exp)
  );

  always_comb begin
    {main_grn_o, main_amb_o, main_red_o, side_grn_o, side_amb_o, side_red_o} = 6'b100001;
    case (phase)
      PH_MAIN_AMBER: {main_grn_o, main_amb_o, main_red_o,
                      side_grn_o, side_amb_o, side_red_o} = 6'b010001;
      PH_SIDE_GO:    {main_grn_o, main_amb_o, main_red_o,
                      side_grn_o, side_amb_o, side_red_o} = 6'b001100;
      PH_SIDE_AMBER: {main_grn_o, main_amb_o, main_red_o,
                      side_grn_o, side_amb_o, side_red_o} = 6'b001010;
      default: ;
    endcase
  end

  // R2: one lamp per road in every cycle
  assert_one_lamp_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($countones({main_grn_o, main_amb_o, main_red_o}) == 1) &&
    ($countones({side_grn_o, side_amb_o, side_red_o}) == 1));

endmodule

// File: tb/junction_signal_ctrl_tb.sv
module junction_signal_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 4;
  localparam int PRESCALE   = 3;
  localparam logic [5:0] L_S0 = 6'b100001;
  localparam logic [5:0] L_S1 = 6'b010001;
  localparam logic [5:0] L_S2 = 6'b001100;
  localparam logic [5:0] L_S3 = 6'b001010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic car = 1'b0;
  logic [LEN_W-1:0] amb_len = '0, gm_len = '0, gs_len = '0, gl_len = '0;
  logic mg, my, mr, sg, sy, sr;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  junction_signal_ctrl #(.LEN_W(LEN_W), .PRESCALE(PRESCALE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .car_raw_i(car),
    .amber_len_i(amb_len), .green_main_len_i(gm_len),
    .green_side_short_i(gs_len), .green_side_long_i(gl_len),
    .main_grn_o(mg), .main_amb_o(my), .main_red_o(mr),
    .side_grn_o(sg), .side_amb_o(sy), .side_red_o(sr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] lamps();
    return {mg, my, mr, sg, sy, sr};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2: one lamp per road, sampled every falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (!($countones({mg, my, mr}) == 1 && $countones({sg, sy, sr}) == 1)) begin
        failures++;
        $display("FAIL R2 actual=%0d expected=one lamp per road", lamps());
      end
    end
  end

  task automatic wait_for(input logic [5:0] code, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (lamps() != code && n < limit);
  endtask

  task automatic run_len(input logic [5:0] code, output int n);
    n = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (lamps() == code) n++;
      else break;
    end
  endtask

  task automatic hold_main(input int cycles, input string tag);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (lamps() != L_S0) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic round(input int a, input int gm, input int gs, input int gl, input bit ext);
    int n;
    amb_len = LEN_W'(a); gm_len = LEN_W'(gm); gs_len = LEN_W'(gs); gl_len = LEN_W'(gl);
    car = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(lamps() == L_S0, "R1 during reset", lamps(), L_S0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(lamps() == L_S0, "R1 after reset", lamps(), L_S0);
    hold_main(gm * PRESCALE + 12, "R3 no request");
    car = 1'b1;
    wait_for(L_S1, 40, n);
    chk(n == 4, "R4 sensor to amber latency", n, 4);
    if (ext) car = 1'b0;
    run_len(L_S1, n);
    chk(n == a * PRESCALE + 1, "R6 main amber length", n, a * PRESCALE + 1);
    chk(lamps() == L_S2, "R11 amber to side green", lamps(), L_S2);
    if (ext) car = 1'b1;
    run_len(L_S2, n);
    chk(n == gs * PRESCALE + 1, "R8 short side green", n, gs * PRESCALE + 1);
    chk(lamps() == L_S3, "R11 side green to side amber", lamps(), L_S3);
    run_len(L_S3, n);
    chk(n == a * PRESCALE + 1, "R6 side amber length", n, a * PRESCALE + 1);
    chk(lamps() == L_S0, "R11 side amber to main green", lamps(), L_S0);
    if (!ext) begin
      hold_main(gm * PRESCALE + 20, "R5 R9 held sensor, no new request");
      car = 1'b0;
      hold_main(10, "R5 sensor release");
    end else begin
      run_len(L_S0, n);
      chk(n == gm * PRESCALE + 1, "R7 main green with request", n, gm * PRESCALE + 1);
      run_len(L_S1, n);
      chk(n == a * PRESCALE + 1, "R6 main amber repeat", n, a * PRESCALE + 1);
      gl_len = LEN_W'(gl + 2);
      gm_len = LEN_W'(gm + 1);
      run_len(L_S2, n);
      chk(n == gl * PRESCALE + 1, "R8 R10 long side green", n, gl * PRESCALE + 1);
      gl_len = LEN_W'(gl);
      gm_len = LEN_W'(gm);
      run_len(L_S3, n);
      chk(n == a * PRESCALE + 1, "R6 side amber repeat", n, a * PRESCALE + 1);
      hold_main(gm * PRESCALE + 20, "R9 request served");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    round(1, 2, 1, 3, 1'b0);
    round(1, 2, 1, 3, 1'b1);
    round(0, 0, 2, 4, 1'b1);
    round(2, 3, 3, 1, 1'b1);
    round(3, 1, 1, 0, 1'b1);
    round(0, 0, 2, 4, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule